// File: doc/BRIEF.md
# Metering Tone Detector with Packet Latch

This block looks for a single metering tone on a line signal that has already been squared into one bit, and reports it on an active-low detect output. Every period and duration is counted in ticks of one fixed reference clock. The tone frequency is one of two values, picked by a system-select input. The rising-edge-to-rising-edge period of the input is measured for each cycle. A cycle counts as a tone cycle only when its period falls inside a tolerance window around the nominal period.

There are two operating modes. In follower mode the output shows whether a tone is present. Changes in both directions are debounced by counting tone cycles. In packet mode the block waits for a tone that lasts at least a programmable minimum, followed by a silence that lasts at least a second programmable minimum. When that silence completes, the output goes low and stays low until an active-low clear strobe is applied.

Top module: `mtone_detect`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, `det_n` is 1 in either mode.
- R2: A cycle is valid only if its rising-edge-to-rising-edge period lies within nominal ±TOL_PCT percent. With `sys_hi`=1 the nominal period is REF_HZ/F_HI ticks, and with `sys_hi`=0 it is REF_HZ/F_LO ticks. A tone at the other system's period is never valid.
- R3: In follower mode, `det_n` falls only after 16 consecutive valid cycles. A burst that gives 15 valid cycles leaves it at 1.
- R4: In follower mode, `det_n` rises only after 16 consecutive invalid intervals. A gap with no edge for the longest valid period counts as one invalid interval. Shorter dropouts leave `det_n` at 0.
- R5: In follower mode, a tone whose period lies outside the window, whether too long or too short, never drives `det_n` low.
- R6: In packet mode, a tone lasting at least `min_tone` ticks, followed by silence lasting at least `min_space` ticks, sets `det_n` to 0 at the end of that silence.
- R7: In packet mode, a tone shorter than `min_tone` does not set the latch.
- R8: In packet mode, if the tone resumes before `min_space` ticks of silence, the latch is not set, and tone timing starts again from zero.
- R9: In packet mode, once latched, `det_n` stays 0 whatever the line input does, until `out_clr_n` is driven 0. On the cycle after that, `det_n` is 1.
- R10: In follower mode, `out_clr_n` has no effect on `det_n`.
- R11: `mode_follow`=1 selects follower mode and `mode_follow`=0 selects packet mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all timing is counted in its ticks |
| rst | input | 1 | Synchronous active-high reset |
| line_sq | input | 1 | Squared line signal (asynchronous) |
| sys_hi | input | 1 | 1: F_HI tone system, 0: F_LO tone system |
| mode_follow | input | 1 | 1: follower mode, 0: packet mode |
| out_clr_n | input | 1 | Active-low clear for the packet latch |
| min_tone | input | DUR_W | Minimum tone duration in ticks (packet mode) |
| min_space | input | DUR_W | Minimum silence duration in ticks (packet mode) |
| det_n | output | 1 | Active-low detect output |

## Verification
The bench sets REF_HZ to 400000, F_HI to 10000 and F_LO to 13333. This gives nominal periods of 40 and 30 ticks and tolerance windows of 38..42 and 29..31. With these values, a 16-cycle debounce and a 16-interval release take only a few hundred ticks. Periods just outside either window are also easy to drive. Minimum tone and space are set to 300 and 200 ticks, so the bench can run short tones, short gaps and complete packets, and compare the two systems against each other.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

    typedef enum logic [1:0] {
        PK_IDLE  = 2'd0,
        PK_TONE  = 2'd1,
        PK_SPACE = 2'd2,
        PK_HOLD  = 2'd3
    } pk_state_e;

    // Nominal tone period in reference ticks, rounded to nearest
    function automatic int nom_ticks(input int ref_hz, input int tone_hz);
        return (ref_hz + tone_hz / 2) / tone_hz;
    endfunction

    // Allowed deviation in ticks for a percentage tolerance
    function automatic int tol_ticks(input int nom, input int pct);
        return (nom * pct) / 100;
    endfunction

endpackage

// File: rtl/mtd_period_meter.sv
module mtd_period_meter #(
    parameter int REF_HZ  = 4433619,
    parameter int F_HI    = 12000,
    parameter int F_LO    = 16000,
    parameter int TOL_PCT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic sq_in,
    input  logic sel_hi,
    output logic cyc_good,
    output logic cyc_bad
);
    import mtd_pkg::*;

    localparam int NOM_HI = nom_ticks(REF_HZ, F_HI);
    localparam int NOM_LO = nom_ticks(REF_HZ, F_LO);
    localparam int HI_MIN = NOM_HI - tol_ticks(NOM_HI, TOL_PCT);
    localparam int HI_MAX = NOM_HI + tol_ticks(NOM_HI, TOL_PCT);
    localparam int LO_MIN = NOM_LO - tol_ticks(NOM_LO, TOL_PCT);
    localparam int LO_MAX = NOM_LO + tol_ticks(NOM_LO, TOL_PCT);
    localparam int TOPV   = (HI_MAX > LO_MAX) ? HI_MAX : LO_MAX;
    localparam int CW     = $clog2(TOPV + 1) + 1;

    localparam logic [CW-1:0] HI_MIN_C = CW'(HI_MIN);
    localparam logic [CW-1:0] HI_MAX_C = CW'(HI_MAX);
    localparam logic [CW-1:0] LO_MIN_C = CW'(LO_MIN);
    localparam logic [CW-1:0] LO_MAX_C = CW'(LO_MAX);

    typedef struct packed {
        logic [2:0]    sh;     // [0],[1] synchroniser, [2] previous level
        logic [CW-1:0] cnt;    // ticks since last rising edge
        logic          armed;  // a previous edge is available as reference
        logic          good;
        logic          bad;
    } meter_t;

    meter_t q, d;
    logic          rise;
    logic [CW-1:0] lim_min, lim_max;

    always_comb begin
        d        = q;
        d.sh     = {q.sh[1:0], sq_in};
        d.good   = 1'b0;
        d.bad    = 1'b0;
        rise     = q.sh[1] & ~q.sh[2];
        lim_min  = sel_hi ? HI_MIN_C : LO_MIN_C;
        lim_max  = sel_hi ? HI_MAX_C : LO_MAX_C;
        if (rise) begin
            d.cnt   = CW'(1);
            d.armed = 1'b1;
            if (q.armed) begin
                if (q.cnt >= lim_min && q.cnt <= lim_max) d.good = 1'b1;
                else                                      d.bad  = 1'b1;
            end
        end else if (q.cnt >= lim_max) begin
            // silence as long as the longest valid period: one invalid interval
            d.bad   = 1'b1;
            d.armed = 1'b0;
            d.cnt   = CW'(1);
        end else begin
            d.cnt   = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign cyc_good = q.good;
    assign cyc_bad  = q.bad;

endmodule

// File: rtl/mtd_debounce.sv
module mtd_debounce #(
    parameter int RUN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_good,
    input  logic cyc_bad,
    output logic tone_on
);
    localparam int RW = $clog2(RUN + 1);
    localparam logic [RW-1:0] LAST_C = RW'(RUN - 1);

    typedef struct packed {
        logic          tone;
        logic [RW-1:0] cnt;
    } deb_t;

    deb_t q, d;

    always_comb begin
        d = q;
        if (!q.tone) begin
            if (cyc_bad) begin
                d.cnt = '0;
            end else if (cyc_good) begin
                if (q.cnt == LAST_C) begin
                    d.tone = 1'b1;
                    d.cnt  = '0;
                end else begin
                    d.cnt  = q.cnt + RW'(1);
                end
            end
        end else begin
            if (cyc_good) begin
                d.cnt = '0;
            end else if (cyc_bad) begin
                if (q.cnt == LAST_C) begin
                    d.tone = 1'b0;
                    d.cnt  = '0;
                end else begin
                    d.cnt  = q.cnt + RW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign tone_on = q.tone;

endmodule

// File: rtl/mtd_packet_fsm.sv
module mtd_packet_fsm #(
    parameter int DUR_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             clr_n,
    input  logic             cyc_good,
    input  logic             cyc_bad,
    input  logic [DUR_W-1:0] min_tone,
    input  logic [DUR_W-1:0] min_space,
    output logic             latched
);
    import mtd_pkg::*;

    typedef struct packed {
        pk_state_e        st;
        logic             live;   // most recent cycle verdict was valid
        logic [DUR_W-1:0] dur;
    } pk_t;

    pk_t q, d;
    logic [DUR_W-1:0] dur_inc;

    always_comb begin
        d       = q;
        dur_inc = (q.dur == '1) ? q.dur : q.dur + DUR_W'(1);
        if (cyc_good)     d.live = 1'b1;
        else if (cyc_bad) d.live = 1'b0;

        if (!enable || !clr_n) begin
            d.st  = PK_IDLE;
            d.dur = '0;
        end else begin
            unique case (q.st)
                PK_IDLE: begin
                    d.dur = '0;
                    if (q.live) d.st = PK_TONE;
                end
                PK_TONE: begin
                    if (q.live) begin
                        d.dur = dur_inc;
                    end else if (q.dur >= min_tone) begin
                        d.st  = PK_SPACE;
                        d.dur = '0;
                    end else begin
                        d.st  = PK_IDLE;
                        d.dur = '0;
                    end
                end
                PK_SPACE: begin
                    if (q.live) begin
                        d.st  = PK_TONE;
                        d.dur = '0;
                    end else if (q.dur >= min_space) begin
                        d.st  = PK_HOLD;
                    end else begin
                        d.dur = dur_inc;
                    end
                end
                PK_HOLD: d.st = PK_HOLD;
                default: d.st = PK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st   <= PK_IDLE;
            q.live <= 1'b0;
            q.dur  <= '0;
        end else begin
            q <= d;
        end
    end

    assign latched = (q.st == PK_HOLD);

endmodule

// File: rtl/mtone_detect.sv
module mtone_detect #(
    parameter int REF_HZ  = 4433619,
    parameter int F_HI    = 12000,
    parameter int F_LO    = 16000,
    parameter int TOL_PCT = 5,
    parameter int RUN     = 16,
    parameter int DUR_W   = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_sq,
    input  logic             sys_hi,
    input  logic             mode_follow,
    input  logic             out_clr_n,
    input  logic [DUR_W-1:0] min_tone,
    input  logic [DUR_W-1:0] min_space,
    output logic             det_n
);
    logic cyc_good, cyc_bad;
    logic tone_on, latched;

    mtd_period_meter #(
        .REF_HZ (REF_HZ),
        .F_HI   (F_HI),
        .F_LO   (F_LO),
        .TOL_PCT(TOL_PCT)
    ) u_meter (
        .clk     (clk),
        .rst     (rst),
        .sq_in   (line_sq),
        .sel_hi  (sys_hi),
        .cyc_good(cyc_good),
        .cyc_bad (cyc_bad)
    );

    mtd_debounce #(.RUN(RUN)) u_deb (
        .clk     (clk),
        .rst     (rst),
        .cyc_good(cyc_good),
        .cyc_bad (cyc_bad),
        .tone_on (tone_on)
    );

    mtd_packet_fsm #(.DUR_W(DUR_W)) u_pkt (
        .clk      (clk),
        .rst      (rst),
        .enable   (~mode_follow),
        .clr_n    (out_clr_n),
        .cyc_good (cyc_good),
        .cyc_bad  (cyc_bad),
        .min_tone (min_tone),
        .min_space(min_space),
        .latched  (latched)
    );

    assign det_n = mode_follow ? ~tone_on : ~latched;

endmodule

// File: rtl/mtd_checker.sv
module mtd_checker (
    input logic clk,
    input logic rst,
    input logic follow,
    input logic clr_n,
    input logic out_n,
    input logic cyc_good,
    input logic cyc_bad
);
    // R1: output inactive after reset
    p_reset_out_r1: assert property (@(posedge clk) rst |=> out_n);

    // R2: one cycle verdict is either valid or invalid, never both
    p_verdict_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(cyc_good && cyc_bad));

    // R3: follower onset only follows a valid cycle verdict
    p_onset_good_r3: assert property (@(posedge clk) disable iff (rst)
        (follow && $past(follow) && $fell(out_n)) |-> $past(cyc_good));

    // R4: follower release only follows an invalid interval
    p_release_bad_r4: assert property (@(posedge clk) disable iff (rst)
        (follow && $past(follow) && $rose(out_n)) |-> $past(cyc_bad));

    // R9: latch holds while the clear strobe is idle
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!follow && $past(!follow && !out_n && clr_n)) |-> !out_n);

    // R9: clear strobe releases the output on the next cycle
    p_clear_rel_r9: assert property (@(posedge clk) disable iff (rst)
        (!follow && $past(!follow && !clr_n)) |-> out_n);

endmodule

bind mtone_detect mtd_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .follow  (mode_follow),
    .clr_n   (out_clr_n),
    .out_n   (det_n),
    .cyc_good(cyc_good),
    .cyc_bad (cyc_bad)
);

// File: tb/mtone_detect_tb.sv
module mtone_detect_tb;
    localparam int DW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          line_sq;
    logic          sys_hi;
    logic          mode_follow;
    logic          out_clr_n;
    logic [DW-1:0] min_tone;
    logic [DW-1:0] min_space;
    logic          det_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mtone_detect #(
        .REF_HZ (400000),
        .F_HI   (10000),
        .F_LO   (13333),
        .TOL_PCT(5),
        .RUN    (16),
        .DUR_W  (DW)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .line_sq    (line_sq),
        .sys_hi     (sys_hi),
        .mode_follow(mode_follow),
        .out_clr_n  (out_clr_n),
        .min_tone   (min_tone),
        .min_space  (min_space),
        .det_n      (det_n)
    );

    task automatic check(input string tag, input logic exp);
        n_chk++;
        if (det_n !== exp) begin
            n_fail++;
            $display("FAIL %s: det_n=%b expected %b at %0t", tag, det_n, exp, $time);
        end
    endtask

    task automatic tone(input int n, input int per);
        for (int i = 0; i < n; i++) begin
            line_sq = 1'b1;
            repeat (per / 2) @(negedge clk);
            line_sq = 1'b0;
            repeat (per - per / 2) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        line_sq = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_r1;
        check("R1 reset state", 1'b1);
    endtask

    task automatic t_onset_r3;
        tone(16, 40); idle(10);
        check("R3 15 valid cycles keep output high", 1'b1);
        idle(900);
        tone(17, 40); idle(10);
        check("R3 16 valid cycles drive output low", 1'b0);
    endtask

    task automatic t_dropout_r4;
        idle(290);
        check("R4 short dropout ignored", 1'b0);
        tone(5, 40); idle(10);
        check("R4 output low after tone resumes", 1'b0);
        idle(800);
        check("R4 long dropout releases output", 1'b1);
    endtask

    task automatic t_offfreq_r5;
        tone(30, 50); idle(10);
        check("R5 period too long rejected", 1'b1);
        idle(100);
        tone(30, 34); idle(10);
        check("R5 period too short rejected", 1'b1);
        idle(900);
    endtask

    task automatic t_select_r2;
        sys_hi = 1'b1;
        tone(30, 30); idle(10);
        check("R2 low-system period rejected on high system", 1'b1);
        idle(200);
        sys_hi = 1'b0;
        tone(30, 30); idle(10);
        check("R2 low-system period accepted", 1'b0);
        idle(800);
        check("R2 release on low system", 1'b1);
        tone(30, 40); idle(10);
        check("R2 high-system period rejected on low system", 1'b1);
        sys_hi = 1'b1;
        idle(900);
    endtask

    task automatic t_strobe_follow_r10;
        tone(20, 40);
        out_clr_n = 1'b0;
        idle(10);
        check("R10 clear strobe ignored in follower mode", 1'b0);
        out_clr_n = 1'b1;
        idle(900);
    endtask

    task automatic t_packet_r6_r7;
        mode_follow = 1'b0;
        idle(20);
        check("R11 packet mode idle output", 1'b1);
        tone(5, 40); idle(600);
        check("R7 short tone does not latch", 1'b1);
        tone(20, 40); idle(150);
        check("R6 no latch before minimum space", 1'b1);
        idle(250);
        check("R6 packet latches output", 1'b0);
    endtask

    task automatic t_hold_r9;
        tone(20, 40); idle(10);
        check("R9 latch ignores tone", 1'b0);
        idle(300);
        check("R9 latch ignores silence", 1'b0);
        out_clr_n = 1'b0;
        repeat (3) @(negedge clk);
        out_clr_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 clear strobe releases latch", 1'b1);
    endtask

    task automatic t_short_space_r8;
        idle(100);
        tone(20, 40); idle(100);
        tone(20, 40); idle(10);
        check("R8 short space does not latch", 1'b1);
        idle(400);
        check("R8 later full packet latches", 1'b0);
        out_clr_n = 1'b0;
        @(negedge clk);
        out_clr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 release after second packet", 1'b1);
    endtask

    initial begin
        rst         = 1'b1;
        line_sq     = 1'b0;
        sys_hi      = 1'b1;
        mode_follow = 1'b1;
        out_clr_n   = 1'b1;
        min_tone    = DW'(300);
        min_space   = DW'(200);
        repeat (5) @(negedge clk);
        t_reset_r1();
        rst = 1'b0;
        idle(60);
        t_reset_r1();
        t_onset_r3();
        t_dropout_r4();
        t_offfreq_r5();
        t_select_r2();
        t_strobe_follow_r10();
        t_packet_r6_r7();
        t_hold_r9();
        t_short_space_r8();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule